// File: doc/BRIEF.md
# Watchdog Timer with Timed Unlock and Timed Refresh

The block is a countdown watchdog for a system that must recover from runaway software. A 32-bit counter is reloaded from a timeout register by a refresh, and counts down one step per clock while the watchdog is enabled. If the count reaches zero before software refreshes it, the block asserts a system reset request for a fixed number of cycles. It also records the cause in a status bit, so that software can find out afterwards why the reset happened.

Software reaches the block through a simple register port: a write strobe, an address, write data and a combinational read-data bus. Both the enable bit and the timeout value are protected. So is a clock-select bit that drives a counter clock multiplexer outside the block. These fields change only after a two-word unlock sequence. The second word must follow the first within a short fixed number of cycles, so the two stores must sit next to each other in the code. Refresh uses its own pair of words under the same timing rule, which makes it unlikely that code running astray refreshes the watchdog by accident. The bus and the counter run on one clock here.

Register map (3-bit address): 0 control (bit 0 enable, bit 1 clock select, 1 = independent oscillator), 1 timeout value, 2 unlock key port, 3 refresh key port, 4 status (bit 0 protection error, bit 1 timeout seen, bit 2 unlock window open; writing a 1 to bit 0 or bit 1 clears that bit), 5 current count (read only).

Top module: `wdg_guard`

## Requirements
- R1: After reset the control register reads 1 (enabled, system clock selected), the timeout register reads 32'hFFFF_FFFF, status reads 0, `clk_sel` is 0 and `rst_req` is 0.
- R2: Writing 16'hA5F0 and then 16'h0F5A to address 2 opens the configuration window when the second write comes 1 to WIN (default 4) cycles after the first. With a larger gap the sequence is discarded. Keys are compared against `wdata[15:0]`.
- R3: A wrong value, or a key out of order, while the unlock sequence waits for its second word returns the sequence to idle, and no window opens.
- R4: A write to address 0 or 1 while the window is closed leaves the register unchanged and sets status bit 0. Writing 1 to status bit 0 clears it.
- R5: The window accepts protected writes in the 256 cycles that follow the accepted second key and closes after that. The first write to the control register also closes it.
- R6: Writing 16'hB480 and then 16'h2C70 to address 3, with the second write 1 to WIN cycles after the first, reloads the counter from the timeout register. Any other pattern leaves the count running.
- R7: While enabled, the count falls by one per cycle. In the cycle after it reads 0, `rst_req` is high, so `rst_req` first goes high T+1 cycles after a refresh with timeout T. The counter then reloads.
- R8: `rst_req` stays high for exactly 16 cycles per expiry. Status bit 1 is set by the expiry and cleared by writing 1 to it.
- R9: While disabled, the counter holds the timeout value and `rst_req` stays low.
- R10: `clk_sel` follows control bit 1 and changes only through an unlocked control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the register port and the counter |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| clk_sel | output | 1 | Counter clock select for the external multiplexer |
| rst_req | output | 1 | System reset request |

## Verification
The bench sweeps the gap between the two unlock words, and between the two refresh words, across the window edge. A window that is off by one would accept a gap of WIN+1 or reject a gap of WIN. It tries a repeated first key, a reversed pair and a foreign word. An unlock state machine that stays armed after any of these would open the window on the following key. It places protected writes on the last open cycle and on the first closed one, and measures the expiry latency and the reset pulse length for several timeouts. A counter that reloads one cycle late, or a pulse counter that is off by one, shows up as a wrong cycle count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_TOVAL   = 3'd1;
    localparam logic [ADDR_W-1:0] A_UNLOCK  = 3'd2;
    localparam logic [ADDR_W-1:0] A_REFRESH = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd4;
    localparam logic [ADDR_W-1:0] A_COUNT   = 3'd5;

    localparam int N_SEQ   = 2;
    localparam int SEQ_UNL = 0;
    localparam int SEQ_REF = 1;

    typedef enum logic {KS_IDLE, KS_ARMED} key_state_e;

    typedef struct packed {
        logic clk_sel;
        logic enable;
    } ctrl_t;

    function automatic logic [15:0] seq_key_a(input int idx);
        return (idx == SEQ_UNL) ? 16'hA5F0 : 16'hB480;
    endfunction

    function automatic logic [15:0] seq_key_b(input int idx);
        return (idx == SEQ_UNL) ? 16'h0F5A : 16'h2C70;
    endfunction

    function automatic logic [ADDR_W-1:0] seq_addr(input int idx);
        return (idx == SEQ_UNL) ? A_UNLOCK : A_REFRESH;
    endfunction

endpackage

// File: rtl/wdg_keyseq.sv
module wdg_keyseq #(
    parameter logic [15:0] KEY_A = 16'h0000,
    parameter logic [15:0] KEY_B = 16'h0000,
    parameter int          WIN   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hit,
    input  logic [15:0] wdata,
    output logic        done
);
    import wdg_pkg::*;

    localparam int AGE_W = $clog2(WIN + 1);

    key_state_e       state_q;
    logic [AGE_W-1:0] age_q;

    assign done = (state_q == KS_ARMED) && hit && (wdata == KEY_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_IDLE;
            age_q   <= AGE_W'(1);
        end else begin
            case (state_q)
                KS_IDLE: begin
                    if (hit && wdata == KEY_A) begin
                        state_q <= KS_ARMED;
                        age_q   <= AGE_W'(1);
                    end
                end
                KS_ARMED: begin
                    if (hit || age_q == AGE_W'(WIN)) begin
                        state_q <= KS_IDLE;
                    end else begin
                        age_q <= age_q + AGE_W'(1);
                    end
                end
                default: state_q <= KS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
    parameter int CW   = 32,
    parameter int HOLD = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          kick,
    input  logic [CW-1:0] reload_val,
    output logic [CW-1:0] cnt,
    output logic          expire,
    output logic          rst_req
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold_q;

    assign expire  = enable && !kick && (cnt == '0);
    assign rst_req = (hold_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '1;
            hold_q <= '0;
        end else begin
            if (!enable || kick || cnt == '0) begin
                cnt <= reload_val;
            end else begin
                cnt <= cnt - CW'(1);
            end
            if (expire) begin
                hold_q <= HW'(HOLD);
            end else if (hold_q != '0) begin
                hold_q <= hold_q - HW'(1);
            end
        end
    end

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard #(
    parameter int DW       = 32,
    parameter int CW       = 32,
    parameter int WIN      = 4,
    parameter int OPEN_CYC = 256,
    parameter int RST_HOLD = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    output logic          clk_sel,
    output logic          rst_req
);
    import wdg_pkg::*;

    localparam int OW = $clog2(OPEN_CYC + 1);

    ctrl_t           ctrl_q;
    logic            en_q;
    logic [CW-1:0]   toval_q;
    logic [CW-1:0]   cnt;
    logic            err_q;
    logic            tmo_q;
    logic [OW-1:0]   open_q;
    logic            win_open;
    logic [N_SEQ-1:0] seq_done;
    logic            unlock_done;
    logic            refresh_done;
    logic            expire;
    logic            wr_prot;
    logic            wr_stat;

    for (genvar g = 0; g < N_SEQ; g++) begin : g_seq
        wdg_keyseq #(
            .KEY_A(seq_key_a(g)),
            .KEY_B(seq_key_b(g)),
            .WIN  (WIN)
        ) u_seq (
            .clk  (clk),
            .rst  (rst),
            .hit  (wr_en && addr == seq_addr(g)),
            .wdata(wdata[15:0]),
            .done (seq_done[g])
        );
    end

    assign unlock_done  = seq_done[SEQ_UNL];
    assign refresh_done = seq_done[SEQ_REF];
    assign win_open     = (open_q != '0);
    assign wr_prot      = wr_en && (addr == A_CTRL || addr == A_TOVAL);
    assign wr_stat      = wr_en && (addr == A_STATUS);
    assign en_q         = ctrl_q.enable;
    assign clk_sel      = ctrl_q.clk_sel;

    wdg_countdown #(
        .CW  (CW),
        .HOLD(RST_HOLD)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .enable    (en_q),
        .kick      (refresh_done),
        .reload_val(toval_q),
        .cnt       (cnt),
        .expire    (expire),
        .rst_req   (rst_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '{clk_sel: 1'b0, enable: 1'b1};
            toval_q <= '1;
            err_q   <= 1'b0;
            tmo_q   <= 1'b0;
            open_q  <= '0;
        end else begin
            if (unlock_done) begin
                open_q <= OW'(OPEN_CYC);
            end else if (wr_en && addr == A_CTRL && win_open) begin
                open_q <= '0;
            end else if (win_open) begin
                open_q <= open_q - OW'(1);
            end

            if (wr_prot && win_open) begin
                if (addr == A_CTRL) begin
                    ctrl_q <= ctrl_t'(wdata[1:0]);
                end else begin
                    toval_q <= wdata[CW-1:0];
                end
            end

            if (wr_prot && !win_open) begin
                err_q <= 1'b1;
            end else if (wr_stat && wdata[0]) begin
                err_q <= 1'b0;
            end

            if (expire) begin
                tmo_q <= 1'b1;
            end else if (wr_stat && wdata[1]) begin
                tmo_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:   rd_data = DW'(ctrl_q);
            A_TOVAL:  rd_data = DW'(toval_q);
            A_STATUS: rd_data = DW'({win_open, tmo_q, err_q});
            A_COUNT:  rd_data = DW'(cnt);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
    parameter int CW   = 32,
    parameter int HOLD = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [2:0]    addr,
    input logic          rst_req,
    input logic          en,
    input logic          kick,
    input logic          win_open,
    input logic          err,
    input logic [CW-1:0] toval,
    input logic [CW-1:0] cnt
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (rst_req) begin
            run_q <= run_q + 32'd1;
        end else begin
            run_q <= '0;
        end
    end

    AST_LOCKED_TOVAL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd1 && !win_open) |=> (toval == $past(toval))); // R4
    AST_LOCKED_ERR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == 3'd0 || addr == 3'd1) && !win_open) |=> err); // R4
    AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt == $past(toval))); // R6
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && !kick && cnt != '0) |=> (cnt == $past(cnt) - CW'(1))); // R7
    AST_EXPIRE_REQ: assert property (@(posedge clk) disable iff (rst)
        (en && !kick && cnt == '0) |=> rst_req); // R7
    AST_REQ_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> (run_q >= 32'(HOLD))); // R8
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !(wr_en && addr == 3'd0)) |=> (cnt == $past(toval))); // R9

endmodule

bind wdg_guard wdg_guard_chk #(
    .CW  (CW),
    .HOLD(RST_HOLD)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .rst_req (rst_req),
    .en      (en_q),
    .kick    (refresh_done),
    .win_open(win_open),
    .err     (err_q),
    .toval   (toval_q),
    .cnt     (cnt)
);

// File: tb/tb_wdg_guard.sv
module tb_wdg_guard;

    localparam int WIN  = 4;
    localparam int OPEN = 256;
    localparam int HOLD = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        clk_sel;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    wdg_guard #(.WIN(WIN), .OPEN_CYC(OPEN), .RST_HOLD(HOLD)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .clk_sel(clk_sel), .rst_req(rst_req)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_watch(input int n, output bit seen);
        seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (rst_req) seen = 1;
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        wr_en = 1'b0; addr = a;
        #1 v = rd_data;
    endtask

    task automatic unlock();
        wr(3'd2, 32'h0000_A5F0);
        wr(3'd2, 32'h0000_0F5A);
    endtask

    task automatic refresh();
        wr(3'd3, 32'h0000_B480);
        wr(3'd3, 32'h0000_2C70);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        bit seen;
        int n;
        int tvals [4] = '{40, 57, 100, 129};

        idle(4);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'd1);
        rd(3'd1, v); chk("R1 toval", v, 32'hFFFF_FFFF);
        rd(3'd4, v); chk("R1 status", v, 32'd0);
        chk("R1 clk_sel", {31'd0, clk_sel}, 32'd0);
        chk("R1 rst_req", {31'd0, rst_req}, 32'd0);

        // R4 locked writes ignored, error sticky, W1C
        wr(3'd1, 32'd100);
        rd(3'd1, v); chk("R4 toval locked", v, 32'hFFFF_FFFF);
        wr(3'd0, 32'd0);
        rd(3'd0, v); chk("R4 ctrl locked", v, 32'd1);
        rd(3'd4, v); chk("R4 err set", v & 32'd1, 32'd1);
        wr(3'd4, 32'd1);
        rd(3'd4, v); chk("R4 err cleared", v & 32'd1, 32'd0);

        // R2 unlock gap sweep
        for (int d = 1; d <= WIN + 3; d++) begin
            wr(3'd2, 32'hFFFF_A5F0);
            idle(d - 1);
            wr(3'd2, 32'h1234_0F5A);
            rd(3'd4, v);
            chk($sformatf("R2 gap %0d", d), (v >> 2) & 32'd1, (d <= WIN) ? 32'd1 : 32'd0);
            if (v[2]) wr(3'd0, 32'd1);
        end

        // R3 wrong values / order
        wr(3'd2, 32'h0F5A); wr(3'd2, 32'h0F5A);
        rd(3'd4, v); chk("R3 reversed", (v >> 2) & 32'd1, 32'd0);
        wr(3'd2, 32'hA5F0); wr(3'd2, 32'hA5F0); wr(3'd2, 32'h0F5A);
        rd(3'd4, v); chk("R3 repeated first key", (v >> 2) & 32'd1, 32'd0);
        wr(3'd2, 32'hA5F0); wr(3'd2, 32'h1234); wr(3'd2, 32'h0F5A);
        rd(3'd4, v); chk("R3 foreign word", (v >> 2) & 32'd1, 32'd0);
        unlock();
        rd(3'd4, v); chk("R3 idle after abort", (v >> 2) & 32'd1, 32'd1);
        wr(3'd0, 32'd1);

        // R5 window length and close on control write
        unlock();
        idle(OPEN - 1);
        wr(3'd1, 32'd77);
        rd(3'd1, v); chk("R5 last open cycle", v, 32'd77);
        wr(3'd1, 32'd88);
        rd(3'd1, v); chk("R5 first closed cycle", v, 32'd77);
        rd(3'd4, v); chk("R5 err after close", v & 32'd1, 32'd1);
        wr(3'd4, 32'd1);
        unlock();
        wr(3'd0, 32'd1);
        rd(3'd4, v); chk("R5 ctrl write closes", (v >> 2) & 32'd1, 32'd0);
        wr(3'd1, 32'd99);
        rd(3'd1, v); chk("R5 write after close", v, 32'd77);
        wr(3'd4, 32'd1);

        // R6/R7/R8 expiry latency and pulse length
        foreach (tvals[i]) begin
            unlock();
            wr(3'd1, tvals[i]);
            wr(3'd0, 32'd1);
            refresh();
            rd(3'd5, v); chk("R6 reload", v, tvals[i]);
            n = 0;
            while (!rst_req && n < 1000) begin @(negedge clk); n++; end
            chk($sformatf("R7 latency T=%0d", tvals[i]), n, tvals[i] + 1);
            rd(3'd4, v); chk("R8 timeout flag", (v >> 1) & 32'd1, 32'd1);
            n = 0;
            while (rst_req && n < 1000) begin @(negedge clk); n++; end
            chk("R8 pulse length", n, HOLD);
            wr(3'd4, 32'd2);
            rd(3'd4, v); chk("R8 flag cleared", (v >> 1) & 32'd1, 32'd0);
        end

        // R6 refresh keeps it alive; refresh gap and order
        unlock();
        wr(3'd1, 32'd40);
        wr(3'd0, 32'd1);
        refresh();
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            bit s;
            idle_watch(30, s);
            if (s) seen = 1;
            refresh();
        end
        chk("R6 alive with refresh", {31'd0, seen}, 32'd0);
        wr(3'd3, 32'hB480); idle(4); wr(3'd3, 32'h2C70);
        rd(3'd5, v); chk("R6 gap 5 no reload", v, 32'd34);
        refresh();
        wr(3'd3, 32'h2C70); wr(3'd3, 32'hB480);
        rd(3'd5, v); chk("R6 reversed no reload", v, 32'd38);
        wr(3'd3, 32'h2C70);
        wr(3'd3, 32'hB480); idle(3); wr(3'd3, 32'h2C70);
        rd(3'd5, v); chk("R6 gap 4 reload", v, 32'd40);

        // R9 disabled
        unlock();
        wr(3'd0, 32'd0);
        idle_watch(200, seen);
        chk("R9 no request", {31'd0, seen}, 32'd0);
        rd(3'd5, v); chk("R9 count held", v, 32'd40);

        // R10 clock select
        unlock();
        wr(3'd0, 32'd2);
        chk("R10 sel set", {31'd0, clk_sel}, 32'd1);
        wr(3'd0, 32'd0);
        chk("R10 locked no change", {31'd0, clk_sel}, 32'd1);
        rd(3'd0, v); chk("R10 ctrl readback", v, 32'd2);
        unlock();
        wr(3'd0, 32'd0);
        chk("R10 sel cleared", {31'd0, clk_sel}, 32'd0);

        finish_run();
    end

endmodule